// File: doc/BRIEF.md
# Wrapping Double-to-Integer Converter

This block turns a 64-bit IEEE-754 binary64 value into a 64-bit two's-complement integer. It runs as a two-stage pipeline that accepts one operand per cycle. The first stage decodes the operand and aligns the significand against the binary point. It splits the value into an integer magnitude and a left-aligned guard word that holds every discarded fraction bit. The second stage picks a rounding increment from the effective rounding mode, applies the sign, and registers the result with its exception flags.

Operands too large for the integer range do not saturate. The result is the low 64 bits of the exact integer, which lets software use one conversion for both signed and unsigned targets. Integer overflow is still flagged, with one exception: -2^63 is exactly representable and raises no flag. A truncate qualifier forces round toward zero whatever the mode input says. A flush control treats subnormal operands as zero.

Top module: `f2i_wrap_cvt`

## Requirements
- R1: A result appears with `out_valid` high exactly two clock cycles after its operand is taken with `in_valid` high. Results leave in issue order, and `out_valid` is low in every other cycle.
- R2: An operand whose exponent field (bits 62:52) is all ones (infinity or NaN) gives result 0, `out_inv` high, and `out_iov` and `out_ine` low.
- R3: An operand with exponent field and fraction both zero (either sign) gives result 0 with no flags. So does a subnormal (exponent 0, fraction nonzero) when `in_ftz` is high.
- R4: A subnormal with `in_ftz` low is an integer part of 0 plus a tiny nonzero remainder below one half. It sets `out_ine`, rounds to +1 under round-up for a positive sign, rounds to -1 under round-down for a negative sign, and rounds to 0 otherwise.
- R5: A finite operand whose value is an integer of magnitude below 2^63 converts exactly, with no flags.
- R6: A finite operand of magnitude 2^63 or more (exponent field 1086 or above) gives the low 64 bits of the exact integer, which is 0 once the magnitude reaches 2^116, and sets `out_iov` and `out_ine`. The single exception is the pattern 0xC3E0000000000000 (-2^63), which gives 0x8000000000000000 with no flags.
- R7: Any nonzero discarded fraction sets `out_ine`.
- R8: In mode 00 (nearest-even) the magnitude rounds to the nearest integer. A remainder of exactly one half rounds to the even neighbour.
- R9: Mode 01 (toward zero) never changes the truncated magnitude. Mode 11 (up) adds one to the magnitude of an inexact positive value only. Mode 10 (down) adds one to the magnitude of an inexact negative value only.
- R10: With `in_chop` high, the result and flags equal those of mode 01, whatever `in_rmode` holds.
- R11: For a negative operand, the result is the two's-complement negation of the rounded magnitude.
- R12: While `rst` is high and in the cycle after it falls, `out_valid`, `out_int` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 64 | binary64 operand |
| in_rmode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 down, 11 up |
| in_chop | input | 1 | Force round toward zero |
| in_ftz | input | 1 | Treat subnormal operands as zero |
| out_valid | output | 1 | Result strobe |
| out_int | output | 64 | Two's-complement integer result |
| out_inv | output | 1 | Invalid-operand flag |
| out_iov | output | 1 | Integer-overflow flag |
| out_ine | output | 1 | Inexact flag |

## Verification
A fault in the alignment stage shows two cycles later as a wrong integer or a wrong inexact flag. The errors cluster at particular exponent distances from the binary point, so operands are weighted toward exponents around the integer range and its overflow boundary. A wrong guard word shows only in the rounding direction. Exact-half ties, the subnormal sticky case and the -2^63 exception are therefore driven under every mode. A stage-valid fault breaks the two-cycle spacing or the issue order at once, and the bench checks both for every result.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_DOWN = 2'b10,
    RM_UP   = 2'b11
  } rmode_e;
endpackage

// File: rtl/f2i_align.sv
// Stage-1 logic: classify the operand and split it into an integer
// magnitude plus a left-aligned guard word of discarded fraction bits.
module f2i_align #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 64
) (
  input  logic [EXP_W+MAN_W:0] op,
  input  logic                 ftz,
  output logic [INT_W-1:0]     mag,
  output logic [INT_W-1:0]     grd,
  output logic                 inv,
  output logic                 iov
);
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int PT     = BIAS + MAN_W;       // exponent where the LSB weighs 1
  localparam int OVF_SH = INT_W - 1 - MAN_W;  // first left shift that overflows
  localparam int SH_W   = EXP_W + 2;
  localparam logic [EXP_W-1:0] EMAX = '1;
  localparam logic [EXP_W-1:0] EMIN_NEG = EXP_W'(BIAS + INT_W - 1);

  logic                   sgn;
  logic [EXP_W-1:0]       ex;
  logic [MAN_W-1:0]       fr;
  logic [INT_W-1:0]       sig;
  logic signed [SH_W-1:0] sh;
  logic [SH_W-1:0]        rs;
  logic                   min_neg;

  assign sgn     = op[EXP_W+MAN_W];
  assign ex      = op[EXP_W+MAN_W-1:MAN_W];
  assign fr      = op[MAN_W-1:0];
  assign sig     = INT_W'({1'b1, fr});
  assign min_neg = sgn && (ex == EMIN_NEG) && (fr == '0);

  always_comb begin
    mag = '0;
    grd = '0;
    inv = 1'b0;
    iov = 1'b0;
    sh  = $signed({2'b00, ex}) - $signed(SH_W'(PT));
    rs  = '0;
    if (ex == EMAX) begin
      inv = 1'b1;
    end else if (ex == '0) begin
      if (fr != '0 && !ftz) grd = INT_W'(1);
    end else if (sh >= 0) begin
      if ($unsigned(sh) < SH_W'(INT_W)) mag = sig << $unsigned(sh);
      iov = ($unsigned(sh) >= SH_W'(OVF_SH)) && !min_neg;
    end else begin
      rs = $unsigned(-sh);
      if (rs < SH_W'(INT_W - 1)) begin
        mag = sig >> rs;
        grd = sig << (SH_W'(INT_W) - rs);
      end else begin
        grd = INT_W'(1);
      end
    end
  end
endmodule

// File: rtl/f2i_round.sv
// Stage-2 logic: choose the increment, apply sign, form the inexact flag.
module f2i_round
  import f2i_pkg::*;
#(
  parameter int INT_W = 64
) (
  input  logic [INT_W-1:0] mag,
  input  logic [INT_W-1:0] grd,
  input  logic             sgn,
  input  rmode_e           mode,
  input  logic             iov,
  output logic [INT_W-1:0] res,
  output logic             ine
);
  localparam logic [INT_W-1:0] HALF = {1'b1, {(INT_W-1){1'b0}}};

  logic             inc;
  logic             frac_nz;
  logic [INT_W-1:0] rnd_mag;

  assign frac_nz = (grd != '0);

  always_comb begin
    unique case (mode)
      RM_NEAR: inc = (grd == HALF) ? mag[0] : (grd > HALF);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = frac_nz && !sgn;
      RM_DOWN: inc = frac_nz && sgn;
      default: inc = 1'b0;
    endcase
  end

  assign rnd_mag = mag + INT_W'(inc);
  assign res     = sgn ? (~rnd_mag + INT_W'(1)) : rnd_mag;
  assign ine     = frac_nz || iov;
endmodule

// File: rtl/f2i_wrap_cvt.sv
module f2i_wrap_cvt
  import f2i_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [EXP_W+MAN_W:0] in_op,
  input  logic [1:0]           in_rmode,
  input  logic                 in_chop,
  input  logic                 in_ftz,
  output logic                 out_valid,
  output logic [INT_W-1:0]     out_int,
  output logic                 out_inv,
  output logic                 out_iov,
  output logic                 out_ine
);
  localparam int SGN_BIT = EXP_W + MAN_W;

  logic [INT_W-1:0] a_mag, a_grd;
  logic             a_inv, a_iov;
  rmode_e           a_mode;

  logic             s1_valid, s1_sgn, s1_inv, s1_iov;
  logic [INT_W-1:0] s1_mag, s1_grd;
  rmode_e           s1_mode;

  logic [INT_W-1:0] r_res;
  logic             r_ine;

  f2i_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_align (
    .op (in_op),
    .ftz(in_ftz),
    .mag(a_mag),
    .grd(a_grd),
    .inv(a_inv),
    .iov(a_iov)
  );

  assign a_mode = in_chop ? RM_ZERO : rmode_e'(in_rmode);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_sgn   <= 1'b0;
      s1_inv   <= 1'b0;
      s1_iov   <= 1'b0;
      s1_mag   <= '0;
      s1_grd   <= '0;
      s1_mode  <= RM_NEAR;
    end else begin
      s1_valid <= in_valid;
      s1_sgn   <= in_op[SGN_BIT];
      s1_inv   <= a_inv;
      s1_iov   <= a_iov;
      s1_mag   <= a_mag;
      s1_grd   <= a_grd;
      s1_mode  <= a_mode;
    end
  end

  f2i_round #(.INT_W(INT_W)) u_round (
    .mag (s1_mag),
    .grd (s1_grd),
    .sgn (s1_sgn),
    .mode(s1_mode),
    .iov (s1_iov),
    .res (r_res),
    .ine (r_ine)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_int   <= '0;
      out_inv   <= 1'b0;
      out_iov   <= 1'b0;
      out_ine   <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      out_int   <= r_res;
      out_inv   <= s1_inv;
      out_iov   <= s1_iov;
      out_ine   <= r_ine;
    end
  end
endmodule

// File: rtl/f2i_wrap_cvt_chk.sv
module f2i_wrap_cvt_chk #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 64
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [EXP_W+MAN_W:0] in_op,
  input logic                 out_valid,
  input logic [INT_W-1:0]     out_int,
  input logic                 out_inv,
  input logic                 out_iov,
  input logic                 out_ine
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R2
  nonfinite_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (&in_op[EXP_W+MAN_W-1:MAN_W])) |-> ##2
    (out_valid && out_inv && !out_iov && !out_ine && out_int == '0));

  // R3
  zero_in_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op[EXP_W+MAN_W-1:0] == '0) |-> ##2
    (out_valid && out_int == '0 && !out_inv && !out_iov && !out_ine));

  // R6
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_iov) |-> (out_ine && !out_inv));
endmodule

bind f2i_wrap_cvt f2i_wrap_cvt_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_op    (in_op),
  .out_valid(out_valid),
  .out_int  (out_int),
  .out_inv  (out_inv),
  .out_iov  (out_iov),
  .out_ine  (out_ine)
);

// File: tb/f2i_wrap_cvt_bench.sv
module f2i_wrap_cvt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QD = 8192;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_op = '0;
  logic [1:0]  in_rmode = '0;
  logic        in_chop = 1'b0;
  logic        in_ftz = 1'b0;
  logic        out_valid;
  logic [63:0] out_int;
  logic        out_inv, out_iov, out_ine;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [66:0] q_exp [QD];
  logic [63:0] q_op  [QD];
  string       q_tag [QD];
  int          q_cyc [QD];
  int          wr = 0;
  int          rd = 0;

  f2i_wrap_cvt u_f2i_wrap_cvt (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_rmode(in_rmode), .in_chop(in_chop), .in_ftz(in_ftz),
    .out_valid(out_valid), .out_int(out_int),
    .out_inv(out_inv), .out_iov(out_iov), .out_ine(out_ine)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference: {inv, iov, ine, result}
  function automatic logic [66:0] ref_cvt(logic [63:0] a, logic [1:0] rm,
                                          logic chop, logic ftz);
    logic        sgn = a[63];
    int          e = int'(a[62:52]);
    logic [51:0] f = a[51:0];
    logic [1:0]  md = chop ? 2'b01 : rm;
    logic [127:0] sig, ip, rem, half;
    logic        ovf = 1'b0, above = 1'b0, tie = 1'b0, inc;
    logic [63:0] r;
    int          s;
    if (e == 2047) return {3'b100, 64'd0};
    if (e == 0 && (f == 0 || ftz)) return 67'd0;
    rem = '0; ip = '0;
    if (e == 0) begin
      rem = 128'd1;
    end else begin
      sig = {75'd0, 1'b1, f};
      s = e - 1075;
      if (s >= 0) begin
        if (s < 64) ip = sig << s;
        ovf = (e >= 1086) && !(sgn && e == 1086 && f == 0);
      end else begin
        s = -s;
        if (s >= 64) rem = sig;
        else begin
          ip = sig >> s;
          rem = sig - (ip << s);
          half = 128'd1 << (s - 1);
          above = rem > half;
          tie = (rem == half);
        end
      end
    end
    case (md)
      2'b00:   inc = above || (tie && ip[0]);
      2'b01:   inc = 1'b0;
      2'b11:   inc = (rem != 0) && !sgn;
      default: inc = (rem != 0) && sgn;
    endcase
    r = ip[63:0] + 64'(inc);
    if (sgn) r = 64'd0 - r;
    return {1'b0, ovf, (rem != 0) || ovf, r};
  endfunction

  function automatic string tag_of(logic [63:0] a, logic [1:0] rm, logic chop, logic ftz);
    int e = int'(a[62:52]);
    if (e == 2047) return "R2";
    if (e == 0) return (a[51:0] == 0 || ftz) ? "R3" : "R4";
    if (e >= 1086) return "R6";
    if (e >= 1075) return "R5";
    if (chop) return "R10";
    if (rm == 2'b00) return "R8";
    if (a[63]) return "R11";
    if (rm != 2'b00) return "R9";
    return "R7";
  endfunction

  task automatic check_out();
    if (out_valid) begin
      checks++;
      if (rd == wr) begin
        errors++;
        $display("FAIL R1 unexpected out_valid: actual 1 expected 0");
      end else begin
        if (cyc - q_cyc[rd] != 2) begin
          errors++;
          $display("FAIL R1 latency op=%h: actual %0d expected 2", q_op[rd], cyc - q_cyc[rd]);
        end
        checks++;
        if ({out_inv, out_iov, out_ine, out_int} !== q_exp[rd]) begin
          errors++;
          $display("FAIL %s op=%h: actual flags=%b int=%h expected flags=%b int=%h",
                   q_tag[rd], q_op[rd], {out_inv, out_iov, out_ine}, out_int,
                   q_exp[rd][66:64], q_exp[rd][63:0]);
        end
        rd++;
      end
    end
  endtask

  task automatic step(logic v, logic [63:0] a, logic [1:0] rm, logic c, logic z);
    @(negedge clk);
    check_out();
    in_valid = v; in_op = a; in_rmode = rm; in_chop = c; in_ftz = z;
    if (v) begin
      q_exp[wr] = ref_cvt(a, rm, c, z);
      q_op[wr]  = a;
      q_tag[wr] = tag_of(a, rm, c, z);
      q_cyc[wr] = cyc;
      wr++;
    end
  endtask

  task automatic all_modes(logic [63:0] a);
    for (int m = 0; m < 4; m++) step(1'b1, a, 2'(m), 1'b0, 1'b0);
    step(1'b1, a, 2'b11, 1'b1, 1'b0);
  endtask

  function automatic logic [63:0] rand_op();
    logic [63:0] a = {$urandom, $urandom};
    int k = int'($urandom % 8);
    int s;
    case (k)
      0: ;
      1: a[62:52] = 11'h7ff;
      2: a[62:52] = 11'd0;
      3: begin
        s = 1 + int'($urandom % 20);
        a[62:52] = 11'(1075 - s);
        a[51:0] = (a[51:0] & ~((52'd1 << s) - 52'd1)) | (52'd1 << (s - 1));
      end
      default: a[62:52] = 11'(1000 + int'($urandom % 100));
    endcase
    return a;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R12: reset state
    checks++;
    if (out_valid !== 1'b0 || out_int !== 64'd0 || {out_inv, out_iov, out_ine} !== 3'b000) begin
      errors++;
      $display("FAIL R12 reset: actual v=%b int=%h expected v=0 int=0", out_valid, out_int);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_int !== 64'd0) begin
      errors++;
      $display("FAIL R12 after reset: actual v=%b int=%h expected v=0 int=0", out_valid, out_int);
    end
    // Directed corners
    step(1'b1, 64'h4000000000000000, 2'b00, 1'b0, 1'b0);  // R5 2.0
    all_modes(64'h3FF8000000000000);                      // 1.5   R8/R9
    all_modes(64'h4004000000000000);                      // 2.5   R8 tie even
    all_modes(64'hC004000000000000);                      // -2.5  R11
    all_modes(64'h3FE0000000000000);                      // 0.5   tie to 0
    all_modes(64'h0000000000000001);                      // R4 subnormal
    all_modes(64'h8000000000000001);                      // R4 negative subnormal
    step(1'b1, 64'h0000000000000001, 2'b11, 1'b0, 1'b1);  // R3 flushed
    step(1'b1, 64'h8000000000000000, 2'b00, 1'b0, 1'b0);  // R3 -0
    step(1'b1, 64'hC3E0000000000000, 2'b00, 1'b0, 1'b0);  // R6 -2^63 exact
    step(1'b1, 64'h43E0000000000000, 2'b00, 1'b0, 1'b0);  // R6 2^63
    step(1'b1, 64'hC3E0000000000001, 2'b00, 1'b0, 1'b0);  // R6 wrap
    step(1'b1, 64'h43F0000000000000, 2'b00, 1'b0, 1'b0);  // R6 2^64 -> 0
    step(1'b1, 64'h4730000000000000, 2'b00, 1'b0, 1'b0);  // R6 huge -> 0
    step(1'b1, 64'h7FF0000000000000, 2'b01, 1'b0, 1'b0);  // R2 +inf
    step(1'b1, 64'hFFF8000000000001, 2'b00, 1'b0, 1'b0);  // R2 NaN
    step(1'b1, 64'h43DFFFFFFFFFFFFF, 2'b00, 1'b0, 1'b0);  // R5 largest in range
    step(1'b1, 64'h3FEFFFFFFFFFFFFF, 2'b00, 1'b0, 1'b0);  // R7 near one
    step(1'b1, 64'h3C00000000000000, 2'b11, 1'b0, 1'b0);  // R7 far-right sticky
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic v = ($urandom % 4) != 0;
      step(v, rand_op(), 2'($urandom), ($urandom % 6) == 0, ($urandom % 4) == 0);
    end
    repeat (4) step(1'b0, 64'd0, 2'b00, 1'b0, 1'b0);
    // R1: everything issued came back
    checks++;
    if (rd != wr) begin
      errors++;
      $display("FAIL R1 drain: actual %0d results expected %0d", rd, wr);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule